// File: doc/BRIEF.md
# Serial Register-Bank Slave

This block is a serial peripheral slave that lets an external host read and write a small bank of 16-bit registers over four wires: an active-low chip select, a serial clock, a data-in line and a data-out line that can be three-stated. Every frame begins with a 16-bit command word, shifted in most significant bit first. The command word carries a fixed enable pattern, a direction bit and a 10-bit starting address. After the command, any number of 16-bit data words may follow while chip select stays low. The register pointer advances after each complete word, so consecutive registers can be streamed in one frame.

The serial pins are oversampled by a faster system clock through two-flop synchronizers, so all state lives in the system clock domain. The serial clock must run well below the system clock: each serial clock level has to hold for at least four system clocks. The bank holds 16 implemented registers at addresses 0 to 15. The pointer still covers the full 10-bit range: reads from unimplemented addresses return zero and writes to them are dropped. The pointer stops at the top address instead of wrapping. A plain read port lets the surrounding chip observe any implemented register. Data-out has a separate enable output that drives the pad three-state. Pattern: command `{11100, rw, addr[9:0]}` sent MSB first, followed by data words.

Top module: `spi_regbank_slave`

## Requirements
- R1: The first 16 bits after chip select falls form the command word, sampled on serial clock rising edges, MSB first. Bits [15:11] = 5'b11100 enable the frame, bit [10] = 1 selects read and 0 selects write, and bits [9:0] give the starting address. Frames work whether the serial clock idles high or low.
- R2: In a write frame, each data word is sampled MSB first on rising edges. It is stored into the register at the pointer once its 16th bit has arrived.
- R3: In a read frame, bit 15 of the addressed register is driven on the first falling edge after the last command bit. The remaining bits follow, MSB first, one per falling edge. The host samples each bit on the following rising edge.
- R4: `spi_miso_oe` is 0 whenever read data is not being driven: during the command word, during write frames, during ignored frames and while chip select is high. While the oe is 0, `spi_miso` is 0.
- R5: In both directions the pointer advances by one after each complete 16-bit data word.
- R6: A data word cut short by chip select rising writes no register.
- R7: Once the pointer reaches 10'h3FF it stays there. Further words read from, or write to, address 10'h3FF, and never address 0.
- R8: A command word whose bits [15:11] are not 5'b11100 makes the slave ignore the rest of the frame. It writes no register and keeps `spi_miso_oe` at 0.
- R9: Chip select rising ends the frame at once, at any bit. The next frame is decoded from a fresh command word.
- R10: Addresses 0 to 15 are implemented registers. Reading any other address returns 16'h0000, and writing one changes no register.
- R11: After reset every register reads 16'h0000 and `spi_miso_oe` is 0.
- R12: `host_rd_data` shows the register selected by `host_rd_idx`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial read data to the host |
| spi_miso_oe | output | 1 | Drive enable for the data-out pad (0 = high impedance) |
| host_rd_idx | input | 4 | Register index for the on-chip read port |
| host_rd_data | output | 16 | Contents of the register at `host_rd_idx` |

## Verification
The assertions check several rules on every cycle. The output enable is off one cycle after chip select is seen high, and it is on only in the read phase. An ignored frame never raises a write strobe. The pointer moves only in single steps within a frame and stays at 10'h3FF once it gets there. A write strobe for an implemented address lands in that register on the next cycle. Only the bench scenarios show the end-to-end serial behaviour: exact bit order and first-bit timing on reads, streaming over several registers, partial-word and abort handling, the enable-pattern check, and zero reads from unimplemented addresses.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  localparam int EN_W = 5;
  localparam logic [EN_W-1:0] EN_PATTERN = 5'b11100;

  typedef enum logic [1:0] {
    PH_CMD    = 2'd0,
    PH_WRITE  = 2'd1,
    PH_READ   = 2'd2,
    PH_IGNORE = 2'd3
  } phase_e;
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_rb_regfile.sv
module spi_rb_regfile #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10,
  parameter int NREG   = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] ra_addr,
  output logic [DATA_W-1:0] ra_data,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic [DATA_W-1:0] rb_data
);
  logic [DATA_W-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     regs[i] <= '0;
      else if (wr_en && (wr_addr == ADDR_W'(i)))      regs[i] <= wr_data;
    end
  end

  assign ra_data = (ra_addr < ADDR_W'(NREG)) ? regs[ra_addr[IDX_W-1:0]] : '0;
  assign rb_data = regs[rb_idx];

  // R2: an accepted write to an implemented address is visible next cycle
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr < ADDR_W'(NREG)))
      |=> (regs[$past(wr_addr[IDX_W-1:0])] == $past(wr_data)));
endmodule

// File: rtl/spi_rb_engine.sv
module spi_rb_engine
  import spi_rb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              sck_s,
  input  logic              mosi_s,
  output logic              wr_en,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] rd_data,
  output logic              miso,
  output logic              miso_oe
);
  localparam int                CNT_W   = $clog2(DATA_W);
  localparam logic [CNT_W-1:0]  LAST    = CNT_W'(DATA_W - 1);
  localparam logic [ADDR_W-1:0] PTR_MAX = {ADDR_W{1'b1}};
  localparam int                RW_BIT  = ADDR_W;

  phase_e              phase;
  logic [CNT_W-1:0]    bit_cnt;
  logic [DATA_W-2:0]   shreg;
  logic [DATA_W-1:0]   out_sr;
  logic [ADDR_W-1:0]   ptr;
  logic                sck_prev, miso_q, oe_q;
  logic                sck_rise, sck_fall, word_end, cmd_ok;
  logic [DATA_W-1:0]   word_in;
  logic [ADDR_W-1:0]   ptr_next;

  assign sck_rise = sck_s & ~sck_prev;
  assign sck_fall = ~sck_s & sck_prev;
  assign word_end = (bit_cnt == LAST);
  assign word_in  = {shreg, mosi_s};
  assign cmd_ok   = (word_in[DATA_W-1 -: EN_W] == EN_PATTERN);
  assign ptr_next = (ptr == PTR_MAX) ? ptr : ptr + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev <= 1'b0;
    else        sck_prev <= sck_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_CMD;
      bit_cnt <= '0;
      shreg   <= '0;
      out_sr  <= '0;
      ptr     <= '0;
      miso_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else if (cs_s) begin
      phase   <= PH_CMD;
      bit_cnt <= '0;
      oe_q    <= 1'b0;
    end else begin
      case (phase)
        PH_CMD: if (sck_rise) begin
          shreg   <= word_in[DATA_W-2:0];
          bit_cnt <= bit_cnt + 1'b1;
          if (word_end) begin
            bit_cnt <= '0;
            if (!cmd_ok) phase <= PH_IGNORE;
            else begin
              ptr   <= word_in[ADDR_W-1:0];
              phase <= word_in[RW_BIT] ? PH_READ : PH_WRITE;
            end
          end
        end
        PH_WRITE: if (sck_rise) begin
          shreg   <= word_in[DATA_W-2:0];
          bit_cnt <= bit_cnt + 1'b1;
          if (word_end) begin
            bit_cnt <= '0;
            ptr     <= ptr_next;
          end
        end
        PH_READ: if (sck_fall) begin
          oe_q    <= 1'b1;
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == '0) begin
            miso_q <= rd_data[DATA_W-1];
            out_sr <= {rd_data[DATA_W-2:0], 1'b0};
          end else begin
            miso_q <= out_sr[DATA_W-1];
            out_sr <= {out_sr[DATA_W-2:0], 1'b0};
          end
          if (word_end) begin
            bit_cnt <= '0;
            ptr     <= ptr_next;
          end
        end
        default: ;
      endcase
    end
  end

  assign wr_en   = (phase == PH_WRITE) && !cs_s && sck_rise && word_end;
  assign wr_data = word_in;
  assign ptr_o   = ptr;
  assign miso    = miso_q & oe_q;
  assign miso_oe = oe_q;

  // R4: chip select high turns the driver off by the next cycle
  p_oe_off_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !miso_oe);
  // R4: the driver is on only inside a read frame
  p_oe_only_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> (phase == PH_READ));
  // R8: an ignored frame never produces a write strobe
  p_ignore_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IGNORE) |-> !wr_en);
  // R7: a pointer at the top address stays there while a frame streams
  p_ptr_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (((phase == PH_READ) || (phase == PH_WRITE)) && (ptr == PTR_MAX))
      |=> (ptr == PTR_MAX));
  // R5: within a data phase the pointer only moves up by exactly one
  p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase != PH_CMD) && ($past(phase) != PH_CMD) && (ptr != $past(ptr)))
      |-> (ptr == ADDR_W'($past(ptr) + 1'b1)));
endmodule

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 10,
  parameter int NREG        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    spi_cs_n,
  input  logic                    spi_sck,
  input  logic                    spi_mosi,
  output logic                    spi_miso,
  output logic                    spi_miso_oe,
  input  logic [$clog2(NREG)-1:0] host_rd_idx,
  output logic [DATA_W-1:0]       host_rd_data
);
  logic              cs_s, sck_s, mosi_s;
  logic              wr_en;
  logic [ADDR_W-1:0] ptr;
  logic [DATA_W-1:0] wr_data, rd_data;

  spi_rb_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_cs_n, spi_sck, spi_mosi}),
    .q     ({cs_s, sck_s, mosi_s})
  );

  spi_rb_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_s    (cs_s),
    .sck_s   (sck_s),
    .mosi_s  (mosi_s),
    .wr_en   (wr_en),
    .ptr_o   (ptr),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .miso    (spi_miso),
    .miso_oe (spi_miso_oe)
  );

  spi_rb_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NREG(NREG)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (ptr),
    .wr_data (wr_data),
    .ra_addr (ptr),
    .ra_data (rd_data),
    .rb_idx  (host_rd_idx),
    .rb_data (host_rd_data)
  );
endmodule

// File: tb/tb_spi_regbank_slave.sv
module tb_spi_regbank_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic        miso, miso_oe;
  logic [3:0]  rd_idx = '0;
  logic [15:0] rd_data;

  int checks = 0, failures = 0;
  logic [15:0] tx [8];
  logic [15:0] rx [8];
  bit rd_oe_ok, oe_seen, in_cmd, oe_in_cmd;

  spi_regbank_slave dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .host_rd_idx(rd_idx), .host_rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (miso_oe) oe_seen = 1'b1;
    if (miso_oe && in_cmd) oe_in_cmd = 1'b1;
    if (!miso_oe && miso) oe_in_cmd = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic half_wait();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic sbit(input logic d, output logic s, output logic oe);
    sck = 1'b0; mosi = d;
    half_wait();
    s = miso; oe = miso_oe;
    sck = 1'b1;
    half_wait();
  endtask

  task automatic frame(input logic [15:0] cmd, input int cmd_bits, input int nwords,
                       input int part_bits, input bit idle_hi);
    logic s, oe;
    oe_seen = 0; oe_in_cmd = 0; rd_oe_ok = 1;
    sck = idle_hi; half_wait();
    cs_n = 1'b0; half_wait();
    in_cmd = 1;
    for (int i = 0; i < cmd_bits; i++) sbit(cmd[15-i], s, oe);
    in_cmd = 0;
    for (int w = 0; w < nwords; w++)
      for (int b = 0; b < 16; b++) begin
        sbit(tx[w][15-b], s, oe);
        rx[w][15-b] = s;
        if (!oe) rd_oe_ok = 0;
      end
    for (int b = 0; b < part_bits; b++) sbit(tx[nwords][15-b], s, oe);
    sck = idle_hi; half_wait();
    cs_n = 1'b1; half_wait(); half_wait();
  endtask

  task automatic peek(input int idx, input logic [15:0] exp, input string req);
    rd_idx = 4'(idx);
    @(negedge clk);
    chk(rd_data === exp, req, rd_data, exp);
  endtask

  task automatic t_reset();
    chk(miso_oe === 1'b0, "R11 oe after reset", {15'd0, miso_oe}, 16'h0);
    peek(0, 16'h0000, "R11 reg0 after reset");
    peek(15, 16'h0000, "R11 reg15 after reset / R12 port");
  endtask

  task automatic t_single_write();
    tx[0] = 16'hA5C3;
    frame(16'hE003, 16, 1, 0, 0);
    peek(3, 16'hA5C3, "R1 R2 single write idle-low");
    chk(!oe_seen, "R4 oe during write frame", {15'd0, oe_seen}, 16'h0);
  endtask

  task automatic t_stream();
    tx[0] = 16'h1111; tx[1] = 16'h2222; tx[2] = 16'h3333;
    frame(16'hE005, 16, 3, 0, 1);
    peek(5, 16'h1111, "R5 stream write word0 idle-high");
    peek(6, 16'h2222, "R5 stream write word1");
    peek(7, 16'h3333, "R5 stream write word2");
    tx[0] = '0; tx[1] = '0; tx[2] = '0;
    frame(16'hE405, 16, 3, 0, 0);
    chk(rx[0] === 16'h1111, "R3 read first word MSB-first", rx[0], 16'h1111);
    chk(rx[1] === 16'h2222, "R5 read second word", rx[1], 16'h2222);
    chk(rx[2] === 16'h3333, "R5 read third word", rx[2], 16'h3333);
    chk(rd_oe_ok, "R3 oe on while data bits sampled", {15'd0, rd_oe_ok}, 16'h1);
    chk(!oe_in_cmd, "R4 oe off during command word", {15'd0, oe_in_cmd}, 16'h0);
    frame(16'hE403, 16, 1, 0, 1);
    chk(rx[0] === 16'hA5C3, "R3 read idle-high", rx[0], 16'hA5C3);
  endtask

  task automatic t_partial();
    tx[0] = 16'hBEEF; tx[1] = 16'hDEAD;
    frame(16'hE008, 16, 1, 9, 0);
    peek(8, 16'hBEEF, "R6 full word before partial");
    peek(9, 16'h0000, "R6 partial word not written");
  endtask

  task automatic t_bad_enable();
    tx[0] = 16'hFFFF;
    frame({5'b10100, 1'b0, 10'd3}, 16, 1, 0, 0);
    peek(3, 16'hA5C3, "R8 bad-enable write ignored");
    chk(!oe_seen, "R8 no drive in bad write frame", {15'd0, oe_seen}, 16'h0);
    frame({5'b11000, 1'b1, 10'd3}, 16, 1, 0, 1);
    chk(!oe_seen, "R8 no drive in bad read frame", {15'd0, oe_seen}, 16'h0);
  endtask

  task automatic t_unimpl();
    tx[0] = 16'h7777;
    frame(16'hE014, 16, 1, 0, 0);
    tx[0] = '0;
    frame(16'hE414, 16, 1, 0, 0);
    chk(rx[0] === 16'h0000, "R10 unimplemented read is zero", rx[0], 16'h0);
    peek(4, 16'h0000, "R10 write to addr 20 hits no register");
    tx[0] = 16'h0F0F;
    frame(16'hE00F, 16, 1, 0, 0);
    tx[0] = '0; tx[1] = '0;
    frame(16'hE40F, 16, 2, 0, 0);
    chk(rx[0] === 16'h0F0F, "R10 reg15 read", rx[0], 16'h0F0F);
    chk(rx[1] === 16'h0000, "R10 R5 past last implemented reads zero", rx[1], 16'h0);
  endtask

  task automatic t_saturate();
    tx[0] = 16'h1234;
    frame(16'hE000, 16, 1, 0, 0);
    peek(0, 16'h1234, "R2 reg0 setup");
    tx[0] = 16'hCAFE; tx[1] = 16'hCAFE; tx[2] = 16'hCAFE;
    frame(16'hE3FE, 16, 3, 0, 0);
    peek(0, 16'h1234, "R7 no wrap on write stream");
    tx[0] = '0; tx[1] = '0;
    frame(16'hE7FF, 16, 2, 0, 1);
    chk(rx[0] === 16'h0000, "R7 top read word0", rx[0], 16'h0);
    chk(rx[1] === 16'h0000, "R7 top read repeats, no wrap", rx[1], 16'h0);
  endtask

  task automatic t_abort();
    tx[0] = '0;
    frame(16'hE405, 16, 0, 8, 0);
    chk(miso_oe === 1'b0, "R9 R4 oe off after abort", {15'd0, miso_oe}, 16'h0);
    frame(16'hE40A, 7, 0, 0, 0);
    tx[0] = 16'h5A5A;
    frame(16'hE00A, 16, 1, 0, 0);
    peek(10, 16'h5A5A, "R9 fresh command after aborts");
    peek(5, 16'h1111, "R9 aborted read left reg5");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%h expected=%h", 16'h1, 16'h0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_single_write();
    t_stream();
    t_partial();
    t_bad_enable();
    t_unimpl();
    t_saturate();
    t_abort();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule